// File: doc/BRIEF.md
# Memory Ordering Dispatch Grouper

This block sits at the dispatch stage of an out-of-order core, in front of a memory dependency tracker. Every dispatched instruction presents three flags: it may read memory, it may write memory, and it has side effects that the scheduler cannot see. For each memory instruction the block returns a group token. Instructions that share a token have no ordering among themselves. The block also emits up to four link requests, each naming an older group that the new group has to follow. The tracker turns these links into readiness. A barrier counts as done once it is the oldest entry in its queue, and all later readiness queries use the token.

The block keeps four current-group registers: the newest load group, the newest load-barrier group, the newest store group and the newest store-barrier group. A configuration bit chooses whether loads may be assumed never to overlap older stores. Tokens come from a wrapping counter that never produces 0, because 0 stands for "no group".

Top module: `mem_order_grouper`

## Requirements
- R1: After reset, all outputs are 0, every current-group register holds 0, and the first memory instruction receives token 1 with no links.
- R2: Each instruction that opens a new group receives the next counter value. The counter counts 1, 2, … up to 2^ID_W−1 and then returns to 1, so no memory instruction ever receives token 0.
- R3: A plain load (no store flag, no side-effect flag) joins the current load group when the previous memory instruction was also a plain load. It then returns that group's token, raises no link, and leaves the counter unchanged.
- R4: Link slot encoding: slot 0 = current store group, slot 1 = current store-barrier group, slot 2 = current load group, slot 3 = current load-barrier group, with slot i on bits [i*ID_W +: ID_W] of `link_src`. A store that opens a group requests slots 0, 1 and 2.
- R5: A load that opens a group requests slot 0 only while `cfg_no_alias` is 0. When `cfg_no_alias` is 1 it never links to a store group.
- R6: Every load that opens a group requests slot 3 (the load-barrier group).
- R7: A load with side effects is a load barrier. It always opens a new group, also requests slot 2, and becomes the current load-barrier group, so the next plain load opens a fresh group.
- R8: A store with side effects becomes the current store-barrier group. An instruction with load, store and side-effect flags all set is a full barrier: it requests all four slots and replaces all four current registers.
- R9: A valid instruction with neither load nor store flag returns token 0, raises no links and changes no state.
- R10: A requested slot whose source is 0, or whose source equals the source of a lower-numbered requested slot, is not raised. The source of an unraised slot reads 0.
- R11: A cycle without `disp_valid` gives all-zero outputs on the next cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_no_alias | input | 1 | 1: loads are assumed not to overlap older stores |
| disp_valid | input | 1 | An instruction is dispatched this cycle |
| disp_ld | input | 1 | Instruction may read memory |
| disp_st | input | 1 | Instruction may write memory |
| disp_fx | input | 1 | Instruction has unmodeled side effects |
| grp_valid | output | 1 | Result for the instruction dispatched one cycle earlier |
| grp_token | output | ID_W | Group token (0 for a non-memory instruction) |
| link_valid | output | 4 | Link request per slot |
| link_src | output | 4*ID_W | Older group per slot, as encoded in R4 |

## Verification
Every result is registered once: the token and the link requests for an instruction sampled at a rising edge appear on the outputs after that edge and stay there for the whole following cycle. The bench drives inputs at the falling edge and compares the outputs one falling edge later, just before it drives the next instruction, so each comparison sees exactly one instruction's result. A bench reference model tracks the four current groups, the plain-load run flag and the counter. A directed sequence walks through joining, barriers, alias mode, duplicate suppression and idle and non-memory cycles. A seeded random run then goes past the counter wrap.

// File: rtl/mem_order_pkg.sv
package mem_order_pkg;
  localparam int NSLOT   = 4;
  localparam int SLOT_ST  = 0;
  localparam int SLOT_SB  = 1;
  localparam int SLOT_LD  = 2;
  localparam int SLOT_LB  = 3;

  typedef struct packed {
    logic ld;
    logic st;
    logic fx;
  } mem_flags_t;
endpackage

// File: rtl/mem_order_state.sv
module mem_order_state
  import mem_order_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fire,
  input  mem_flags_t                  flg,
  output logic [NSLOT-1:0][ID_W-1:0]  cur_ids,
  output logic                        join_grp,
  output logic [ID_W-1:0]             tok
);
  localparam logic [ID_W-1:0] ID_MAX = {ID_W{1'b1}};
  localparam logic [ID_W-1:0] ID_ONE = {{(ID_W-1){1'b0}}, 1'b1};

  logic [NSLOT-1:0][ID_W-1:0] cur_q, cur_d;
  logic [ID_W-1:0]            next_q, next_d;
  logic                       plain_q, plain_d;
  logic                       is_mem, alloc, plain_op;

  always_comb begin
    is_mem   = flg.ld | flg.st;
    plain_op = flg.ld & ~flg.st & ~flg.fx;
    join_grp = fire & plain_op & plain_q;
    alloc    = fire & is_mem & ~join_grp;
    if (!is_mem)       tok = '0;
    else if (join_grp) tok = cur_q[SLOT_LD];
    else               tok = next_q;
  end

  always_comb begin
    cur_d   = cur_q;
    next_d  = next_q;
    plain_d = plain_q;
    if (alloc) begin
      next_d = (next_q == ID_MAX) ? ID_ONE : next_q + ID_ONE;
      if (flg.ld)          cur_d[SLOT_LD] = next_q;
      if (flg.ld & flg.fx) cur_d[SLOT_LB] = next_q;
      if (flg.st)          cur_d[SLOT_ST] = next_q;
      if (flg.st & flg.fx) cur_d[SLOT_SB] = next_q;
    end
    if (fire & is_mem) plain_d = plain_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      next_q  <= ID_ONE;
      plain_q <= 1'b0;
    end else begin
      if (alloc)         cur_q   <= cur_d;
      if (alloc)         next_q  <= next_d;
      if (fire & is_mem) plain_q <= plain_d;
    end
  end

  assign cur_ids = cur_q;

  // R2: counter never yields 0
  p_next_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    next_q != '0);
  // R3: joining does not consume an identifier
  p_join_keeps_ctr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    join_grp |=> $stable(next_q));
  // R7: a load barrier always opens a fresh group
  p_lbar_no_join_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && flg.ld && flg.fx) |-> !join_grp);
endmodule

// File: rtl/mem_order_links.sv
module mem_order_links
  import mem_order_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  logic                        fire,
  input  logic                        join_grp,
  input  logic                        no_alias,
  input  mem_flags_t                  flg,
  input  logic [NSLOT-1:0][ID_W-1:0]  cur_ids,
  output logic [NSLOT-1:0]            lnk_vld,
  output logic [NSLOT-1:0][ID_W-1:0]  lnk_src
);
  logic [NSLOT-1:0] need, cand;

  always_comb begin
    need          = '0;
    need[SLOT_ST] = flg.st | (flg.ld & ~no_alias);
    need[SLOT_SB] = flg.st;
    need[SLOT_LD] = flg.st | (flg.ld & flg.fx);
    need[SLOT_LB] = flg.ld;
  end

  genvar gi;
  generate
    for (gi = 0; gi < NSLOT; gi++) begin : g_slot
      logic dup;
      assign cand[gi] = fire & ~join_grp & need[gi] & (cur_ids[gi] != '0);
      always_comb begin
        dup = 1'b0;
        for (int j = 0; j < gi; j++)
          if (cand[j] && (cur_ids[j] == cur_ids[gi])) dup = 1'b1;
      end
      assign lnk_vld[gi] = cand[gi] & ~dup;
      assign lnk_src[gi] = lnk_vld[gi] ? cur_ids[gi] : '0;
    end
  endgenerate
endmodule

// File: rtl/mem_order_grouper.sv
module mem_order_grouper
  import mem_order_pkg::*;
#(
  parameter int ID_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_no_alias,
  input  logic                    disp_valid,
  input  logic                    disp_ld,
  input  logic                    disp_st,
  input  logic                    disp_fx,
  output logic                    grp_valid,
  output logic [ID_W-1:0]         grp_token,
  output logic [NSLOT-1:0]        link_valid,
  output logic [NSLOT*ID_W-1:0]   link_src
);
  logic                       rs_meta, rs_n;
  mem_flags_t                 flg;
  logic                       fire, join_grp;
  logic [ID_W-1:0]            tok;
  logic [NSLOT-1:0][ID_W-1:0] cur_ids, lnk_src;
  logic [NSLOT-1:0]           lnk_vld;

  logic                       vld_q, vld_d;
  logic [ID_W-1:0]            tok_q, tok_d;
  logic [NSLOT-1:0]           lv_q, lv_d;
  logic [NSLOT-1:0][ID_W-1:0] ls_q, ls_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  assign flg  = '{ld: disp_ld, st: disp_st, fx: disp_fx};
  assign fire = disp_valid;

  mem_order_state #(.ID_W(ID_W)) u_state (
    .clk(clk), .rst_n(rs_n), .fire(fire), .flg(flg),
    .cur_ids(cur_ids), .join_grp(join_grp), .tok(tok)
  );

  mem_order_links #(.ID_W(ID_W)) u_links (
    .fire(fire), .join_grp(join_grp), .no_alias(cfg_no_alias), .flg(flg),
    .cur_ids(cur_ids), .lnk_vld(lnk_vld), .lnk_src(lnk_src)
  );

  always_comb begin
    vld_d = fire;
    tok_d = fire ? tok : '0;
    lv_d  = fire ? lnk_vld : '0;
    ls_d  = fire ? lnk_src : '0;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      vld_q <= 1'b0;
      tok_q <= '0;
      lv_q  <= '0;
      ls_q  <= '0;
    end else begin
      vld_q <= vld_d;
      tok_q <= tok_d;
      lv_q  <= lv_d;
      ls_q  <= ls_d;
    end
  end

  assign grp_valid  = vld_q;
  assign grp_token  = tok_q;
  assign link_valid = lv_q;
  assign link_src   = ls_q;

  // R9: non-memory instruction gives token 0 and no links
  p_nonmem_quiet_r9: assert property (@(posedge clk) disable iff (!rs_n)
    (disp_valid && !disp_ld && !disp_st) |=> (grp_token == '0 && link_valid == '0));
  // R11: idle cycle gives all-zero outputs
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rs_n)
    !disp_valid |=> (!grp_valid && grp_token == '0 && link_valid == '0 && link_src == '0));
  // R2: memory instruction always receives a nonzero token
  p_mem_tok_nz_r2: assert property (@(posedge clk) disable iff (!rs_n)
    (disp_valid && (disp_ld || disp_st)) |=> grp_token != '0);
  // R5: with no-alias set, a plain load never links to a store group
  p_noalias_r5: assert property (@(posedge clk) disable iff (!rs_n)
    (disp_valid && disp_ld && !disp_st && cfg_no_alias) |=> !link_valid[SLOT_ST]);
  // R3: a joining load raises no link
  p_join_nolink_r3: assert property (@(posedge clk) disable iff (!rs_n)
    join_grp |=> link_valid == '0);
  // R10: a raised slot never names group 0
  p_src_nz_r10: assert property (@(posedge clk) disable iff (!rs_n)
    (link_valid[0] -> link_src[ID_W-1:0] != '0));
endmodule

// File: tb/sim_mem_order_grouper.sv
`timescale 1ns/1ps
module sim_mem_order_grouper;
  localparam int ID_W = 6;
  localparam int NS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_no_alias = 1'b0, disp_valid = 1'b0, disp_ld = 1'b0, disp_st = 1'b0, disp_fx = 1'b0;
  logic grp_valid;
  logic [ID_W-1:0] grp_token;
  logic [NS-1:0] link_valid;
  logic [NS*ID_W-1:0] link_src;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mem_order_grouper #(.ID_W(ID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_no_alias(cfg_no_alias), .disp_valid(disp_valid),
    .disp_ld(disp_ld), .disp_st(disp_st), .disp_fx(disp_fx), .grp_valid(grp_valid),
    .grp_token(grp_token), .link_valid(link_valid), .link_src(link_src)
  );

  // reference state
  logic [ID_W-1:0] m_cur [NS];
  logic [ID_W-1:0] m_next;
  logic            m_plain;
  logic            e_vld;
  logic [ID_W-1:0] e_tok;
  logic [NS-1:0]   e_lv;
  logic [NS*ID_W-1:0] e_ls;
  string           e_tag;
  logic            have_exp = 1'b0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic v, input logic ld, input logic st, input logic fx, input logic na);
    logic [NS-1:0] need;
    e_vld = v; e_tok = '0; e_lv = '0; e_ls = '0;
    if (!v || !(ld || st)) return;
    if (ld && !st && !fx && m_plain) begin
      e_tok = m_cur[2];
      return;
    end
    e_tok = m_next;
    need[0] = st | (ld & ~na);
    need[1] = st;
    need[2] = st | (ld & fx);
    need[3] = ld;
    for (int i = 0; i < NS; i++) begin
      logic d;
      d = 1'b0;
      for (int j = 0; j < i; j++)
        if (e_lv[j] && m_cur[j] == m_cur[i]) d = 1'b1;
      if (need[i] && m_cur[i] != '0 && !d) begin
        e_lv[i] = 1'b1;
        e_ls[i*ID_W +: ID_W] = m_cur[i];
      end
    end
    if (ld)       m_cur[2] = m_next;
    if (ld && fx) m_cur[3] = m_next;
    if (st)       m_cur[0] = m_next;
    if (st && fx) m_cur[1] = m_next;
    m_next = (m_next == '1) ? 1 : m_next + 1;
    m_plain = ld & ~st & ~fx;
  endtask

  task automatic compare();
    if (!have_exp) return;
    chk(e_tag, "grp_valid", 32'(grp_valid), 32'(e_vld));
    chk(e_tag, "grp_token", 32'(grp_token), 32'(e_tok));
    chk(e_tag, "link_valid", 32'(link_valid), 32'(e_lv));
    chk(e_tag, "link_src", 32'(link_src), 32'(e_ls));
  endtask

  task automatic step(input string tag, input logic v, input logic ld, input logic st,
                      input logic fx, input logic na);
    @(negedge clk);
    compare();
    disp_valid = v; disp_ld = ld; disp_st = st; disp_fx = fx; cfg_no_alias = na;
    model(v, ld, st, fx, na);
    e_tag = tag;
    if (tag == "") begin
      if (!v) e_tag = "R11";
      else if (!(ld || st)) e_tag = "R9";
      else if (e_lv == '0 && ld && !st && !fx && e_tok != m_next - 1 && e_tok != '1) e_tag = "R3";
      else if (e_tok == 1) e_tag = "R2";
      else if (ld && st && fx) e_tag = "R8";
      else if (st) e_tag = "R4";
      else if (fx) e_tag = "R7";
      else e_tag = "R6";
    end
    have_exp = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    for (int i = 0; i < NS; i++) m_cur[i] = '0;
    m_next = 1; m_plain = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "reset grp_valid", 32'(grp_valid), 0);
    chk("R1", "reset grp_token", 32'(grp_token), 0);
    chk("R1", "reset link_valid", 32'(link_valid), 0);
    // directed sequence
    step("R1",  1, 1, 0, 0, 0);  // load -> token 1, no links
    step("R3",  1, 1, 0, 0, 0);  // joins group 1
    step("R4",  1, 0, 1, 0, 0);  // store -> 2, links load 1
    step("R5",  1, 1, 0, 0, 0);  // load -> 3, links store 2
    step("R3",  1, 1, 0, 0, 0);  // joins 3
    step("R7",  1, 1, 0, 1, 0);  // load barrier -> 4
    step("R6",  1, 1, 0, 0, 0);  // load -> 5, links barrier 4
    step("R8",  1, 0, 1, 1, 0);  // store barrier -> 6
    step("R10", 1, 0, 1, 0, 0);  // store -> 7, store & barrier both 6: one link
    step("R9",  1, 0, 0, 1, 0);  // non-memory
    step("R11", 0, 1, 1, 1, 0);  // idle
    step("R5",  1, 1, 0, 0, 1);  // load no-alias -> 8, no store link
    step("R8",  1, 1, 1, 1, 1);  // full barrier -> 9
    step("R7",  1, 1, 0, 1, 1);  // load barrier after full barrier
    // random run, past counter wrap
    for (int n = 0; n < 600; n++) begin
      int unsigned r;
      r = $urandom(seed);
      seed = seed + 32'd7919;
      step("", (r[3:0] != 0), r[4] | r[8], r[5] & r[9], (r[7:6] == 2'b11), r[10]);
    end
    step("R11", 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule